// File: doc/BRIEF.md
# Dependency-Tracked Register Slot Allocator

This block places a virtual front end before a register file whose architectural index space is large and sparse. Examples are special-purpose registers numbered across a 10-bit space. Tracking each of those indices individually in a dependency matrix is too costly. The block therefore maps them dynamically onto a small pool of tracked slots. An external dependency matrix owns two bitvectors with one bit per slot: a read-pending vector and a write-pending vector. Those two vectors alone decide when a slot's mapping may be released. No explicit free or commit command exists.

Each cycle, an issue stage may present a request carrying an architectural index. The block first searches the valid slots associatively. On a match it returns the slot that already holds that index. On a miss it claims the lowest-numbered free slot and records the index there. It gives the slot number in the same cycle in both one-hot and binary form. When the index is not mapped and no slot is free, the block raises a combinational stall. Issue to function units must then hold.

Each slot runs a small state machine:

- `SLOT_FREE` holds no mapping.
- `SLOT_FRESH` is the one-cycle grace state after a claim or a reuse hit.
- `SLOT_HELD` is a mapping protected by the pending bits.

The transitions are as follows:

- *claim*: FREE to FRESH, on a miss that selects this slot.
- *settle*: FRESH to HELD, on the next edge when there is no new hit.
- *retouch*: FRESH or HELD to FRESH, on an accepted hit.
- *release*: HELD to FREE, when both pending bits are clear and there is no hit.

The grace state gives the dependency matrix one cycle to raise the slot's bits after a claim.

Top module: `slot_alloc`

## Requirements
- R1: A synchronous active-high reset empties every slot, so the first request after reset misses and is granted slot 0.
- R2: On a miss, the block grants the request in the same cycle. It drives `slot_bin` with the slot number and `slot_oh` with only bit n set for slot n, with `hit` low.
- R3: A request whose index is already mapped returns that slot with `hit` high, and no other slot is claimed.
- R4: A slot in the free state is available only when both its read-pending and write-pending bits are clear.
- R5: A slot claimed at an edge stays mapped and unavailable for the following cycle, even if its pending bits are still clear.
- R6: A mapping survives while either pending bit of its slot is set. After the grace cycle, it is released at the first edge where both bits are clear, and a later request for that index misses.
- R7: `stall` equals request valid AND lookup miss AND no available slot. While `stall` is high, `grant` is low and `slot_oh` is zero, and a hit is never stalled.
- R8: Without a grant, `slot_oh` is zero. With a grant, exactly one bit of `slot_oh` is set.
- R9: Among several available slots, the lowest-numbered one is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Allocation request present |
| req_idx | input | IDX_W | Architectural register index of the request |
| rd_pend | input | NSLOTS | Read-pending bit per slot from the dependency matrix |
| wr_pend | input | NSLOTS | Write-pending bit per slot from the dependency matrix |
| grant | output | 1 | Request accepted this cycle |
| hit | output | 1 | Index was already mapped |
| slot_oh | output | NSLOTS | Granted slot, one-hot |
| slot_bin | output | SLOT_W | Granted slot, binary |
| stall | output | 1 | No slot can be given; issue must hold |

## Verification
The bench uses the default build of eight slots and 10-bit indices. This keeps filling the whole pool to a stall only a few requests away. It plays the dependency matrix itself, setting and clearing pending bits cycle by cycle. That covers the grace cycle, release after both bits drop, blocking by a single pending bit on an unmapped slot, and reuse of a released slot. Several slots are released at once to show that the lowest-numbered slot wins.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_FRESH = 2'd1,
        SLOT_HELD  = 2'd2
    } slot_state_e;

endpackage

// File: rtl/slot_ctrl.sv
module slot_ctrl
    import slot_alloc_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             claim,
    input  logic             take,
    input  logic [IDX_W-1:0] new_idx,
    input  logic             rd_p,
    input  logic             wr_p,
    output logic             valid_o,
    output logic             avail_o,
    output logic [IDX_W-1:0] idx_o
);

    slot_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic pend_any;

    assign pend_any = rd_p | wr_p;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:  if (claim) state_d = SLOT_FRESH;
            SLOT_FRESH: state_d = take ? SLOT_FRESH : SLOT_HELD;
            SLOT_HELD: begin
                if (take)           state_d = SLOT_FRESH;
                else if (!pend_any) state_d = SLOT_FREE;
            end
            default:    state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_FREE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (claim) idx_q <= new_idx;
        end
    end

    always_comb begin
        valid_o = 1'b0;
        avail_o = 1'b0;
        unique case (state_q)
            SLOT_FREE:  avail_o = !pend_any;
            SLOT_FRESH: valid_o = 1'b1;
            SLOT_HELD:  valid_o = 1'b1;
            default:    valid_o = 1'b0;
        endcase
        idx_o = idx_q;
    end

    p_claim_avail_r4: assert property (@(posedge clk) disable iff (rst)
        claim |-> (!rd_p && !wr_p && !valid_o));

    p_grace_r5: assert property (@(posedge clk) disable iff (rst)
        claim |=> (valid_o && !avail_o));

    p_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && pend_any) |=> valid_o);

    p_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_HELD && !pend_any && !take) |=> !valid_o);

endmodule

// File: rtl/slot_match.sv
module slot_match #(
    parameter int NSLOTS = 8,
    parameter int IDX_W  = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NSLOTS-1:0]           valid_vec,
    input  logic [NSLOTS-1:0][IDX_W-1:0] idx_vec,
    input  logic [IDX_W-1:0]            key,
    output logic [NSLOTS-1:0]           hit_vec
);

    for (genvar g = 0; g < NSLOTS; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (idx_vec[g] == key);
    end

    p_unique_map_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: rtl/low_pick.sv
module low_pick #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req_vec,
    output logic [N-1:0] pick_oh,
    output logic [W-1:0] pick_bin,
    output logic         any
);

    always_comb begin
        pick_oh  = '0;
        pick_bin = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_vec[i]) begin
                pick_oh     = '0;
                pick_oh[i]  = 1'b1;
                pick_bin    = W'(i);
            end
        end
        any = |req_vec;
    end

endmodule

// File: rtl/slot_alloc.sv
module slot_alloc #(
    parameter int NSLOTS = 8,
    parameter int IDX_W  = 10,
    localparam int SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [NSLOTS-1:0] rd_pend,
    input  logic [NSLOTS-1:0] wr_pend,
    output logic              grant,
    output logic              hit,
    output logic [NSLOTS-1:0] slot_oh,
    output logic [SLOT_W-1:0] slot_bin,
    output logic              stall
);

    logic [NSLOTS-1:0]            valid_vec, avail_vec, hit_vec;
    logic [NSLOTS-1:0]            claim_vec, take_vec;
    logic [NSLOTS-1:0][IDX_W-1:0] idx_vec;
    logic [NSLOTS-1:0]            free_oh, hit_oh;
    logic [SLOT_W-1:0]            free_bin, hit_bin;
    logic                         any_free, any_hit;

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        slot_ctrl #(.IDX_W(IDX_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .claim   (claim_vec[g]),
            .take    (take_vec[g]),
            .new_idx (req_idx),
            .rd_p    (rd_pend[g]),
            .wr_p    (wr_pend[g]),
            .valid_o (valid_vec[g]),
            .avail_o (avail_vec[g]),
            .idx_o   (idx_vec[g])
        );
    end

    slot_match #(.NSLOTS(NSLOTS), .IDX_W(IDX_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .idx_vec   (idx_vec),
        .key       (req_idx),
        .hit_vec   (hit_vec)
    );

    low_pick #(.N(NSLOTS)) u_free_pick (
        .req_vec  (avail_vec),
        .pick_oh  (free_oh),
        .pick_bin (free_bin),
        .any      (any_free)
    );

    low_pick #(.N(NSLOTS)) u_hit_enc (
        .req_vec  (hit_vec),
        .pick_oh  (hit_oh),
        .pick_bin (hit_bin),
        .any      (any_hit)
    );

    always_comb begin
        stall     = req_valid && !any_hit && !any_free;
        grant     = req_valid && !stall;
        hit       = req_valid && any_hit;
        claim_vec = (grant && !any_hit) ? free_oh : '0;
        take_vec  = (grant &&  any_hit) ? hit_oh  : '0;
        if (!grant) begin
            slot_oh  = '0;
            slot_bin = '0;
        end else if (any_hit) begin
            slot_oh  = hit_oh;
            slot_bin = hit_bin;
        end else begin
            slot_oh  = free_oh;
            slot_bin = free_bin;
        end
    end

    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (valid_vec == '0));

    p_stall_block_r7: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!grant && slot_oh == '0));

    p_hit_no_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit) |-> !stall);

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        grant |-> ($countones(slot_oh) == 1));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !grant |-> (slot_oh == '0));

    p_no_double_claim_r5: assert property (@(posedge clk) disable iff (rst)
        (grant && !hit) |=> ($countones(valid_vec) >= 1));

endmodule

// File: tb/sim_slot_alloc.sv
module sim_slot_alloc;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOTS = 8;
    localparam int IDX_W  = 10;
    localparam int SLOT_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [IDX_W-1:0]  req_idx = '0;
    logic [NSLOTS-1:0] rd_pend = '0;
    logic [NSLOTS-1:0] wr_pend = '0;
    logic              grant, hit, stall;
    logic [NSLOTS-1:0] slot_oh;
    logic [SLOT_W-1:0] slot_bin;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_alloc #(.NSLOTS(NSLOTS), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
        .rd_pend(rd_pend), .wr_pend(wr_pend), .grant(grant), .hit(hit),
        .slot_oh(slot_oh), .slot_bin(slot_bin), .stall(stall)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Drive one request for one cycle and check the same-cycle response.
    task automatic req(input int idx, input bit e_hit, input int e_bin, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_idx   = IDX_W'(idx);
        #1;
        chk({tag, " grant"}, int'(grant), 1);
        chk({tag, " stall"}, int'(stall), 0);
        chk({tag, " hit"}, int'(hit), int'(e_hit));
        chk({tag, " slot_bin"}, int'(slot_bin), e_bin);
        chk({tag, " slot_oh"}, int'(slot_oh), 1 << e_bin);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic set_pend(input logic [NSLOTS-1:0] r, input logic [NSLOTS-1:0] w);
        @(negedge clk);
        rd_pend = r;
        wr_pend = w;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            chk("R8 idle slot_oh", int'(slot_oh), 0);
            chk("R7 idle stall", int'(stall), 0);
        end
    endtask

    task automatic t_reset_first();
        @(negedge clk);
        #1;
        chk("R1 reset grant", int'(grant), 0);
        chk("R8 reset slot_oh", int'(slot_oh), 0);
        req(5, 1'b0, 0, "R1 R2 first miss");
        set_pend(8'h00, 8'h01);
    endtask

    task automatic t_hit();
        req(5, 1'b1, 0, "R3 reuse hit");
        req(9, 1'b0, 1, "R3 no extra claim");
        set_pend(8'h02, 8'h01);
    endtask

    task automatic t_grace();
        req(20, 1'b0, 2, "R5 claim a");
        req(21, 1'b0, 3, "R5 grace skip");
        set_pend(8'h02, 8'h0D);
    endtask

    task automatic t_pend_block();
        set_pend(8'h12, 8'h0D);
        req(30, 1'b0, 5, "R4 pending skip");
        set_pend(8'h02, 8'h2D);
        req(31, 1'b0, 4, "R4 now free");
        set_pend(8'h02, 8'h3D);
    endtask

    task automatic t_full_stall();
        req(40, 1'b0, 6, "R7 fill 6");
        set_pend(8'h02, 8'h7D);
        req(41, 1'b0, 7, "R7 fill 7");
        set_pend(8'h02, 8'hFD);
        idle(1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_idx   = IDX_W'(50);
            #1;
            chk("R7 stall high", int'(stall), 1);
            chk("R7 no grant", int'(grant), 0);
            chk("R7 slot_oh zero", int'(slot_oh), 0);
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req(5, 1'b1, 0, "R7 hit when full");
    endtask

    task automatic t_release();
        set_pend(8'h0A, 8'hF5);
        idle(2);
        req(21, 1'b1, 3, "R6 kept by read pend");
        set_pend(8'h02, 8'hF5);
        idle(3);
        req(21, 1'b0, 3, "R6 released then miss");
        set_pend(8'h02, 8'hFD);
    endtask

    task automatic t_priority();
        set_pend(8'h00, 8'hBD);
        idle(3);
        req(60, 1'b0, 1, "R9 lowest first");
        set_pend(8'h02, 8'hBD);
        req(61, 1'b0, 6, "R9 next lowest");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset_first();
        t_hit();
        t_grace();
        t_pend_block();
        t_full_stall();
        t_release();
        t_priority();
        idle(2);
        finish_run();
    end

endmodule